// File: doc/BRIEF.md
# Multiplier-Free Parallel FIR Filter

This block is a 16-tap finite impulse response filter with fixed coefficients that forms every product without a multiplier. Accepted samples enter a delay line. Each bit plane of the stored taps is split into groups of four. Each group's four bits address a small 16-entry table, and every entry holds the sum of the coefficients that its set address bits select. The table outputs are weighted by their bit position with shifts, and the sign-bit plane is subtracted. An adder tree then combines the results.

All eight bit planes are evaluated in the same cycle, so the filter accepts one sample per clock. It returns one result per accepted sample after a fixed latency of three clock edges. The coefficients come from a parameter vector, and the tables are computed from it at elaboration time. A surrounding datapath drives a valid-qualified sample stream and takes results from the output whenever the output valid is high.

Top module: `da_fir_top`

## Requirements
- R1: While rst_ni is low, out_valid_o is 0 and y_o is 0. The delay line and all pipeline registers are cleared.
- R2: out_valid_o is high after the third rising edge that follows an edge where in_valid_i was sampled high, and it is low otherwise. Samples may arrive on every cycle.
- R3: The result for sample n is y = sum over k=0..15 of c[k]·x[n−k]. Here x[n−k] is the k-th most recently accepted sample, as 8-bit two's complement. c[k] is the signed 16-bit value at bits [16k+15:16k] of COEFS_P. y_o is the exact 28-bit two's complement integer sum, with no rounding or saturation.
- R4: A cycle with in_valid_i low does not shift the delay line. After an idle gap, the next result uses only the accepted samples, in order of arrival.
- R5: While no new result is due, y_o keeps the value of the last result.
- R6: After reset, the sample history is zero. The first results after reset therefore use zero for taps that have not yet received a sample (an impulse of 1 returns c[0], c[1], ... in turn).
- R7: Bit 7 of a sample has weight −128. An input of −128 against any coefficient, including −32768, gives the exact product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Sample on x_i is accepted this edge |
| x_i | input | 8 | Input sample, two's complement |
| out_valid_o | output | 1 | New filter result on y_o |
| y_o | output | 28 | Filter result, two's complement, full precision |

## Verification
A corrupt delay-line tap shows as a wrong y_o three edges after the next accepted sample. The error then persists until that sample has moved past the last tap, 16 accepted samples later. A bad table entry appears only for the bit patterns that address it. For this reason the random stimulus mixes all signs and magnitudes, and directed runs of −128 and impulses reach the extreme and single-coefficient entries. A fault in the valid pipeline or in the idle-hold behaviour shows on the first cycle it occurs, because y_o and out_valid_o are compared on every cycle and not only on valid ones.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;
  localparam int unsigned DEF_TAPS = 16;
  localparam int unsigned DEF_DW   = 8;
  localparam int unsigned DEF_CW   = 16;
  localparam int unsigned DEF_GSZ  = 4;
  // c[15] first, c[0] last
  localparam logic [DEF_TAPS*DEF_CW-1:0] DEF_COEFS = {
    16'h0200, 16'hC000, 16'h4000, 16'hFFFF,
    16'h0001, 16'h0800, 16'hD000, 16'h3000,
    16'hFEDC, 16'h0123, 16'h8000, 16'h7FFF,
    16'h2000, 16'h1000, 16'hF800, 16'h0400
  };
endpackage

// File: rtl/da_fir_delay.sv
module da_fir_delay #(
  parameter int unsigned TAPS = 16,
  parameter int unsigned DW   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shift_i,
  input  logic [DW-1:0]      din_i,
  output logic [TAPS*DW-1:0] taps_o
);
  // tap k at [k*DW +: DW] holds x[n-k]
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      taps_o <= '0;
    else if (shift_i) taps_o <= {taps_o[(TAPS-1)*DW-1:0], din_i};
  end

  p_tap_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(taps_o));
endmodule

// File: rtl/da_fir_group.sv
module da_fir_group #(
  parameter int unsigned DW  = 8,
  parameter int unsigned CW  = 16,
  parameter int unsigned GSZ = 4,
  parameter logic [GSZ*CW-1:0] GCOEF = '0,
  localparam int unsigned LN = 1 << GSZ,
  localparam int unsigned LW = CW + $clog2(GSZ),
  localparam int unsigned GW = DW + CW + $clog2(GSZ)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [GSZ*DW-1:0]    taps_i,
  output logic signed [GW-1:0] sum_o
);
  function automatic logic [LN*LW-1:0] build_lut();
    logic [LN*LW-1:0]    tbl;
    logic signed [LW-1:0] acc;
    tbl = '0;
    for (int a = 0; a < LN; a++) begin
      acc = '0;
      for (int j = 0; j < GSZ; j++)
        if (a[j]) acc = acc + LW'($signed(GCOEF[j*CW +: CW]));
      tbl[a*LW +: LW] = acc;
    end
    return tbl;
  endfunction

  localparam logic [LN*LW-1:0] LUT = build_lut();

  logic [DW*GW-1:0] terms_flat;

  for (genvar b = 0; b < DW; b++) begin : g_bit
    logic [GSZ-1:0]       addr;
    logic signed [LW-1:0] part;
    logic signed [GW-1:0] ext;
    for (genvar j = 0; j < GSZ; j++) begin : g_addr
      assign addr[j] = taps_i[j*DW + b];
    end
    assign part = LUT[addr*LW +: LW];
    assign ext  = GW'(part);
    if (b == DW - 1) begin : g_sign
      assign terms_flat[b*GW +: GW] = -(ext <<< b);
    end else begin : g_mag
      assign terms_flat[b*GW +: GW] = ext <<< b;
    end
  end

  logic signed [GW-1:0] acc_d;
  always_comb begin
    acc_d = '0;
    for (int b = 0; b < DW; b++) acc_d = acc_d + $signed(terms_flat[b*GW +: GW]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_o <= '0;
    else         sum_o <= acc_d;
  end

  p_grp_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(taps_i) |=> $stable(sum_o));
endmodule

// File: rtl/da_fir_top.sv
module da_fir_top
  import da_fir_pkg::*;
#(
  parameter int unsigned TAPS = DEF_TAPS,
  parameter int unsigned DW   = DEF_DW,
  parameter int unsigned CW   = DEF_CW,
  parameter int unsigned GSZ  = DEF_GSZ,
  parameter logic [TAPS*CW-1:0] COEFS_P = DEF_COEFS,
  localparam int unsigned NGRP = TAPS / GSZ,
  localparam int unsigned GW   = DW + CW + $clog2(GSZ),
  localparam int unsigned OW   = DW + CW + $clog2(TAPS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [DW-1:0] x_i,
  output logic          out_valid_o,
  output logic [OW-1:0] y_o
);
  logic [TAPS*DW-1:0] taps;
  logic [NGRP*GW-1:0] grp_flat;
  logic [1:0]         vld_q;

  da_fir_delay #(.TAPS(TAPS), .DW(DW)) u_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(in_valid_i),
    .din_i  (x_i),
    .taps_o (taps)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic signed [GW-1:0] gsum;
    da_fir_group #(
      .DW   (DW),
      .CW   (CW),
      .GSZ  (GSZ),
      .GCOEF(COEFS_P[g*GSZ*CW +: GSZ*CW])
    ) u_grp (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .taps_i(taps[g*GSZ*DW +: GSZ*DW]),
      .sum_o (gsum)
    );
    assign grp_flat[g*GW +: GW] = gsum;
  end

  logic signed [OW-1:0] tot_d;
  always_comb begin
    tot_d = '0;
    for (int g = 0; g < NGRP; g++) tot_d = tot_d + OW'($signed(grp_flat[g*GW +: GW]));
  end

  // pipeline runs every cycle; valid travels alongside
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q       <= '0;
      out_valid_o <= 1'b0;
      y_o         <= '0;
    end else begin
      vld_q       <= {vld_q[0], in_valid_i};
      out_valid_o <= vld_q[1];
      y_o         <= tot_d;
    end
  end

  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cyc_q <= '0;
    else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 2'd1;
  end

  p_vld_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3) |-> (out_valid_o == $past(in_valid_i, 3)));

  p_y_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_q[1] |=> $stable(y_o));

  p_idle_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_q[1] |=> !out_valid_o);
endmodule

// File: tb/da_fir_top_tb.sv
`timescale 1ns/1ps
module da_fir_top_tb;
  import da_fir_pkg::*;

  localparam int OW = 28;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid_i = 1'b0;
  logic [7:0]    x_i = '0;
  logic          out_valid_o;
  logic [OW-1:0] y_o;

  int checks = 0;
  int errors = 0;

  longint xs[16];
  longint yh[3];
  bit     vh[3];
  string  th[3];

  always #2.5 clk_i = ~clk_i;

  da_fir_top u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .x_i        (x_i),
    .out_valid_o(out_valid_o),
    .y_o        (y_o)
  );

  function automatic longint coef(int k);
    return longint'($signed(DEF_COEFS[k*16 +: 16]));
  endfunction

  function automatic longint model();
    longint s = 0;
    for (int k = 0; k < 16; k++) s += coef(k) * xs[k];
    return s;
  endfunction

  task automatic clear_hist();
    for (int k = 0; k < 16; k++) xs[k] = 0;
    for (int i = 0; i < 3; i++) begin yh[i] = 0; vh[i] = 0; th[i] = "R1"; end
  endtask

  task automatic check_ports();
    longint got;
    got = longint'($signed(y_o));
    checks++;
    if (out_valid_o !== vh[2]) begin
      errors++;
      $display("FAIL R2: out_valid_o=%0b expected %0b", out_valid_o, vh[2]);
    end
    checks++;
    if (got !== yh[2]) begin
      errors++;
      $display("FAIL %s: y_o=%0d expected %0d", th[2], got, yh[2]);
    end
  endtask

  task automatic step(bit v, logic [7:0] x, string tag);
    @(negedge clk_i);
    check_ports();
    for (int i = 2; i > 0; i--) begin yh[i] = yh[i-1]; vh[i] = vh[i-1]; th[i] = th[i-1]; end
    if (v) begin
      for (int k = 15; k > 0; k--) xs[k] = xs[k-1];
      xs[0] = longint'($signed(x));
      yh[0] = model();
    end else begin
      yh[0] = yh[1];
    end
    vh[0] = v;
    th[0] = tag;
    in_valid_i = v;
    x_i = x;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    in_valid_i = 1'b0;
    x_i = '0;
    clear_hist();
    for (int i = 0; i < 2; i++) begin
      @(negedge clk_i);
      checks++;
      if (out_valid_o !== 1'b0 || y_o !== '0) begin
        errors++;
        $display("FAIL R1: out_valid_o=%0b y_o=%0d expected 0 0", out_valid_o, $signed(y_o));
      end
    end
    rst_ni = 1'b1;
  endtask

  bit finished = 1'b0;

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    clear_hist();
    r = $urandom(32'd20240611);
    do_reset();

    // impulse after reset walks out each coefficient
    step(1'b1, 8'd1, "R6");
    for (int i = 0; i < 18; i++) step(1'b1, 8'd0, "R6");
    step(1'b1, 8'hFF, "R6");

    // random stream, valid about 3 of 4 cycles
    for (int i = 0; i < 400; i++) begin
      bit v;
      v = ($urandom % 4) != 0;
      step(v, 8'($urandom), v ? "R3" : "R5");
    end

    // idle gaps between accepted samples
    for (int i = 0; i < 20; i++) begin
      for (int j = 0; j < (i % 5) + 1; j++) step(1'b0, 8'($urandom), "R5");
      step(1'b1, 8'($urandom), "R4");
    end

    // sign-bit extremes
    for (int i = 0; i < 18; i++) step(1'b1, 8'h80, "R7");
    for (int i = 0; i < 18; i++) step(1'b1, (i % 2) ? 8'h80 : 8'h7F, "R7");

    // reset mid-run clears the history
    do_reset();
    step(1'b1, 8'h80, "R6");
    for (int i = 0; i < 17; i++) step(1'b1, 8'd0, "R6");

    for (int i = 0; i < 5; i++) step(1'b0, 8'd0, "R5");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule